// File: doc/BRIEF.md
# USB Receive Packet Buffer Writer

This block stores the data stage of an OUT or SETUP transaction in a packet memory that is 16 bits wide. A transaction starts with a one-cycle pulse that carries the endpoint number. The block then fetches that endpoint's buffer descriptor over a valid/ready read port. The descriptor has two words: a byte start address and a count word. The count word encodes how much memory is allocated to the endpoint.

After the fetch, the block accepts received bytes one per cycle and packs them in pairs into memory words. It counts every byte. It also counts down the space that is left, and it stops writing once the allocation is full. The two CRC bytes are stored like data when they fit. The packet ends with either an end-of-packet strobe or an error strobe. A clean end writes the byte count back into the descriptor and leaves the allocation fields untouched. An error or an overrun ends the transaction as failed, and memory that was already written is not rolled back.

Top module: `usb_rx_bufwr`

## Requirements
- R1: After reset, and at any time no transaction is open, `desc_rd_req`, `rx_ready`, `mem_we`, `desc_wr_en`, `xfer_ok` and `xfer_fail` are low. Byte, end and error strobes that arrive while idle cause no memory or descriptor write.
- R2: A `xfer_start` pulse raises `desc_rd_req` on the next cycle, with `desc_rd_ep` equal to the endpoint that was sampled. The request stays high until `desc_rd_ack` is seen. `rx_ready` stays low until that handshake completes, so no byte is accepted during the fetch.
- R3: The first memory word goes to the byte address given in the descriptor's address word, which is expected to be even. Each following word goes to the next even address, 2 higher.
- R4: Within a word, the earlier byte of each pair sits in bits 7:0 and the later byte in bits 15:8. Every accepted byte adds one to the byte count, and every stored byte takes one from the remaining space.
- R5: The count word holds a size-unit flag in bit 15, a block number in bits 14:10 and the byte count in bits 9:0. With the flag at 0 the allocation is block number × 2 bytes. With the flag at 1 it is (block number + 1) × 32 bytes. No word is written past the allocation.
- R6: When the packet fits, every received byte is stored, the two CRC bytes included.
- R7: When the payload (bytes received minus 2) is larger than the allocation, the transaction ends with `xfer_fail` and no descriptor write. A payload exactly equal to the allocation succeeds, and its CRC bytes are dropped.
- R8: A packet that ends on an odd byte has its last byte written in bits 7:0 of one more word, with bits 15:8 set to zero.
- R9: `rx_err` ends the transaction with `xfer_fail` and no descriptor write. Words already written are kept, and a pending odd byte is still written out.
- R10: A clean end pulses `xfer_ok` and `desc_wr_en` in the same cycle. `desc_wr_ep` is the transaction's endpoint. `desc_wr_cnt` carries bits 15:10 as fetched and the number of bytes received (low 10 bits) in bits 9:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Opens a transaction (one-cycle pulse) |
| xfer_ep | input | EP_W | Endpoint of the new transaction |
| desc_rd_req | output | 1 | Descriptor read request (valid) |
| desc_rd_ep | output | EP_W | Endpoint whose descriptor is requested |
| desc_rd_ack | input | 1 | Descriptor data valid (ready) |
| desc_rd_addr | input | ADDR_W | Buffer start byte address |
| desc_rd_cnt | input | 16 | Count word with allocation fields |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_eop | input | 1 | Packet ended cleanly (with rx_valid low) |
| rx_err | input | 1 | Packet ended with a reception error (with rx_valid low) |
| rx_ready | output | 1 | Byte is accepted when high together with rx_valid |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | ADDR_W | Even byte address of the word written |
| mem_wdata | output | 16 | Word written |
| desc_wr_en | output | 1 | Count word write-back strobe |
| desc_wr_ep | output | EP_W | Endpoint of the write-back |
| desc_wr_cnt | output | 16 | Count word written back |
| xfer_ok | output | 1 | Pulse: transaction succeeded |
| xfer_fail | output | 1 | Pulse: transaction failed (error or overrun) |

## Verification
The hardest cases sit at the allocation boundary. A payload exactly as large as the allocation must still succeed even though its CRC bytes are dropped, and one byte more must fail. The stimulus reaches both sides by choosing small allocations (6 bytes) and sending exactly 8 and then 9 bytes. A 32-byte-unit descriptor is also filled to its last word. A second hard case is a byte already presented while the descriptor fetch is still pending. The bench holds `rx_valid` high through a delayed `desc_rd_ack` and checks that `rx_ready` stays low and that the first stored word still starts with that byte.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

    localparam int CNT_W  = 10;
    localparam int NB_W   = 5;
    localparam int WORD_W = 16;

    typedef struct packed {
        logic            unit32;
        logic [NB_W-1:0] nblk;
        logic [CNT_W-1:0] cnt;
    } cnt_word_t;

    typedef struct packed {
        logic            unit32;
        logic [NB_W-1:0] nblk;
    } alloc_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RECV  = 2'd2
    } rx_state_e;

    function automatic logic [15:0] alloc_bytes(input alloc_t a);
        if (a.unit32)
            return (16'(a.nblk) + 16'd1) << 5;
        else
            return 16'(a.nblk) << 1;
    endfunction

endpackage

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
    import usb_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xfer_start,
    input  logic      desc_ack,
    input  logic      rx_valid,
    input  logic      rx_eop,
    input  logic      rx_err,
    output rx_state_e state,
    output logic      load,
    output logic      accept,
    output logic      fin_ok,
    output logic      fin_err
);

    rx_state_e state_q;

    assign state   = state_q;
    assign load    = (state_q == ST_FETCH) && desc_ack;
    assign accept  = (state_q == ST_RECV) && rx_valid;
    assign fin_err = (state_q == ST_RECV) && !rx_valid && rx_err;
    assign fin_ok  = (state_q == ST_RECV) && !rx_valid && rx_eop && !rx_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (xfer_start) state_q <= ST_FETCH;
                ST_FETCH: if (desc_ack)   state_q <= ST_RECV;
                ST_RECV:  if (fin_ok || fin_err) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: receive phase only entered through a completed descriptor handshake
    assert_recv_after_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECV && $past(state_q) != ST_RECV) |-> $past(desc_ack));

endmodule

// File: rtl/usb_rx_packer.sv
module usb_rx_packer
    import usb_rx_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_addr,
    input  cnt_word_t         cnt_word,
    input  logic              accept,
    input  logic [7:0]        rx_data,
    input  logic              fin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [15:0]       byte_cnt,
    output logic [15:0]       cap,
    output alloc_t            alloc,
    output logic              overrun
);

    logic [ADDR_W-1:0] base_q;
    logic [15:0]       cnt_q;
    logic [15:0]       space_q;
    logic [15:0]       cap_q;
    logic [7:0]        lo_q;
    logic              lo_pend_q;
    logic [1:0]        drop_q;
    alloc_t            alloc_q;

    logic room, hi_pos, wr_full, wr_flush;

    assign room     = (space_q != 16'd0);
    assign hi_pos   = cnt_q[0];
    assign wr_full  = accept && room && hi_pos;
    assign wr_flush = fin && lo_pend_q;

    assign mem_we    = wr_full || wr_flush;
    assign mem_wdata = wr_full ? {rx_data, lo_q} : {8'h00, lo_q};
    assign mem_addr  = base_q + ADDR_W'({cnt_q[15:1], 1'b0});
    assign byte_cnt  = cnt_q;
    assign cap       = cap_q;
    assign alloc     = alloc_q;
    // three bytes beyond the allocation means the payload itself did not fit
    assign overrun   = (drop_q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            cnt_q     <= '0;
            space_q   <= '0;
            cap_q     <= '0;
            lo_q      <= '0;
            lo_pend_q <= 1'b0;
            drop_q    <= '0;
            alloc_q   <= '0;
        end else if (load) begin
            base_q    <= base_addr;
            cnt_q     <= '0;
            alloc_q   <= '{unit32: cnt_word.unit32, nblk: cnt_word.nblk};
            space_q   <= alloc_bytes('{unit32: cnt_word.unit32, nblk: cnt_word.nblk});
            cap_q     <= alloc_bytes('{unit32: cnt_word.unit32, nblk: cnt_word.nblk});
            lo_pend_q <= 1'b0;
            drop_q    <= '0;
        end else if (accept) begin
            cnt_q <= cnt_q + 16'd1;
            if (room) begin
                space_q <= space_q - 16'd1;
                if (!hi_pos) begin
                    lo_q      <= rx_data;
                    lo_pend_q <= 1'b1;
                end else begin
                    lo_pend_q <= 1'b0;
                end
            end else if (drop_q != 2'd3) begin
                drop_q <= drop_q + 2'd1;
            end
        end else if (fin) begin
            lo_pend_q <= 1'b0;
        end
    end

    assert_clip_to_alloc_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (16'(mem_addr - base_q) < cap_q));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cnt_q == $past(cnt_q) + 16'd1));

    assert_space_step_R4: assert property (@(posedge clk) disable iff (rst)
        (accept && room) |=> (space_q == $past(space_q) - 16'd1));

endmodule

// File: rtl/usb_rx_bufwr.sv
module usb_rx_bufwr
    import usb_rx_pkg::*;
#(
    parameter int EP_W   = 3,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic [EP_W-1:0]   xfer_ep,
    output logic              desc_rd_req,
    output logic [EP_W-1:0]   desc_rd_ep,
    input  logic              desc_rd_ack,
    input  logic [ADDR_W-1:0] desc_rd_addr,
    input  logic [15:0]       desc_rd_cnt,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_eop,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    output logic              desc_wr_en,
    output logic [EP_W-1:0]   desc_wr_ep,
    output logic [15:0]       desc_wr_cnt,
    output logic              xfer_ok,
    output logic              xfer_fail
);

    rx_state_e       state;
    logic            load, accept, fin_ok, fin_err, overrun;
    logic [15:0]     byte_cnt, cap;
    alloc_t          alloc;
    logic [EP_W-1:0] ep_q;

    always_ff @(posedge clk) begin
        if (rst)
            ep_q <= '0;
        else if (state == ST_IDLE && xfer_start)
            ep_q <= xfer_ep;
    end

    usb_rx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .desc_ack   (desc_rd_ack),
        .rx_valid   (rx_valid),
        .rx_eop     (rx_eop),
        .rx_err     (rx_err),
        .state      (state),
        .load       (load),
        .accept     (accept),
        .fin_ok     (fin_ok),
        .fin_err    (fin_err)
    );

    usb_rx_packer #(.ADDR_W(ADDR_W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .base_addr (desc_rd_addr),
        .cnt_word  (cnt_word_t'(desc_rd_cnt)),
        .accept    (accept),
        .rx_data   (rx_data),
        .fin       (fin_ok || fin_err),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .byte_cnt  (byte_cnt),
        .cap       (cap),
        .alloc     (alloc),
        .overrun   (overrun)
    );

    assign desc_rd_req = (state == ST_FETCH);
    assign desc_rd_ep  = ep_q;
    assign rx_ready    = (state == ST_RECV);
    assign xfer_ok     = fin_ok && !overrun;
    assign xfer_fail   = fin_err || (fin_ok && overrun);
    assign desc_wr_en  = xfer_ok;
    assign desc_wr_ep  = ep_q;
    assign desc_wr_cnt = {alloc.unit32, alloc.nblk, byte_cnt[CNT_W-1:0]};

    // R7: a successful write-back never follows more bytes than allocation plus CRC
    assert_wb_within_alloc_R7: assert property (@(posedge clk) disable iff (rst)
        desc_wr_en |-> (17'(byte_cnt) <= 17'(cap) + 17'd2));

    // R1: no memory traffic outside an open receive phase
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (state != ST_RECV) |-> !mem_we && !desc_wr_en);

endmodule

// File: tb/usb_rx_bufwr_tb_top.sv
module usb_rx_bufwr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int EP_W   = 3;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              xfer_start = 1'b0;
    logic [EP_W-1:0]   xfer_ep = '0;
    logic              desc_rd_req;
    logic [EP_W-1:0]   desc_rd_ep;
    logic              desc_rd_ack = 1'b0;
    logic [ADDR_W-1:0] desc_rd_addr = '0;
    logic [15:0]       desc_rd_cnt = '0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic              rx_eop = 1'b0;
    logic              rx_err = 1'b0;
    logic              rx_ready;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [15:0]       mem_wdata;
    logic              desc_wr_en;
    logic [EP_W-1:0]   desc_wr_ep;
    logic [15:0]       desc_wr_cnt;
    logic              xfer_ok;
    logic              xfer_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_rx_bufwr #(.EP_W(EP_W), .ADDR_W(ADDR_W)) dut_i (.*);

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] wl_addr [64];
    logic [15:0] wl_data [64];
    int          wn = 0;
    int          dn = 0;
    logic [15:0] d_cnt;
    logic [EP_W-1:0] d_ep;
    int          ok_n = 0;
    int          fail_n = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (wn < 64) begin
                    wl_addr[wn] = mem_addr;
                    wl_data[wn] = mem_wdata;
                end
                wn++;
            end
            if (desc_wr_en) begin
                d_cnt = desc_wr_cnt;
                d_ep  = desc_wr_ep;
                dn++;
            end
            if (xfer_ok)   ok_n++;
            if (xfer_fail) fail_n++;
        end
    end

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'(seed * 13 + k * 7 + 1);
    endfunction

    task automatic clear_logs();
        wn = 0; dn = 0; ok_n = 0; fail_n = 0;
    endtask

    // Runs one transaction; err_at > 0 ends with rx_err after err_at bytes
    task automatic run_pkt(input int seed, input int ep, input int base, input int u32,
                           input int nb, input int total, input int err_at,
                           input int ack_delay, input bit hold_valid);
        int cap, sent, written, expw, exp_ok;
        clear_logs();
        cap  = (u32 != 0) ? (nb + 1) * 32 : nb * 2;
        sent = (err_at > 0) ? err_at : total;
        @(posedge clk); #1;
        xfer_start = 1'b1; xfer_ep = EP_W'(ep);
        @(posedge clk); #1;
        xfer_start = 1'b0; xfer_ep = '0;
        if (hold_valid) begin rx_valid = 1'b1; rx_data = pat(seed, 0); end
        for (int d = 0; d < ack_delay; d++) begin
            @(negedge clk);
            chk(desc_rd_req == 1'b1, "R2", "desc_rd_req during fetch", int'(desc_rd_req), 1);
            chk(rx_ready == 1'b0, "R2", "rx_ready during fetch", int'(rx_ready), 0);
            @(posedge clk); #1;
        end
        @(negedge clk);
        chk(desc_rd_ep == EP_W'(ep), "R2", "desc_rd_ep", int'(desc_rd_ep), ep);
        @(posedge clk); #1;
        desc_rd_ack = 1'b1;
        desc_rd_addr = ADDR_W'(base);
        desc_rd_cnt = {1'(u32), 5'(nb), 10'h3a5};
        @(posedge clk); #1;
        desc_rd_ack = 1'b0;
        for (int k = 0; k < sent; k++) begin
            rx_valid = 1'b1; rx_data = pat(seed, k);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0;
        if (err_at > 0) rx_err = 1'b1; else rx_eop = 1'b1;
        @(posedge clk); #1;
        rx_err = 1'b0; rx_eop = 1'b0;
        @(negedge clk);
        written = (sent < cap) ? sent : cap;
        expw    = (written + 1) / 2;
        exp_ok  = (err_at == 0 && total <= cap + 2) ? 1 : 0;
        chk(wn == expw, "R5", "memory word count", wn, expw);
        for (int i = 0; i < expw && i < wn && i < 64; i++) begin
            logic [15:0] ew;
            ew[7:0]  = pat(seed, 2 * i);
            ew[15:8] = (2 * i + 1 < written) ? pat(seed, 2 * i + 1) : 8'h00;
            chk(wl_addr[i] == 16'(base + 2 * i), "R3", "word address", int'(wl_addr[i]), base + 2 * i);
            if (2 * i + 1 < written)
                chk(wl_data[i] == ew, "R4", "packed word", int'(wl_data[i]), int'(ew));
            else
                chk(wl_data[i] == ew, "R8", "odd tail word", int'(wl_data[i]), int'(ew));
        end
        chk(ok_n == exp_ok, "R10", "xfer_ok pulses", ok_n, exp_ok);
        chk(fail_n == 1 - exp_ok, "R7", "xfer_fail pulses", fail_n, 1 - exp_ok);
        if (exp_ok != 0) begin
            chk(dn == 1, "R10", "write-back count", dn, 1);
            chk(d_cnt == {1'(u32), 5'(nb), 10'(total)}, "R10", "write-back word",
                int'(d_cnt), int'({1'(u32), 5'(nb), 10'(total)}));
            chk(d_ep == EP_W'(ep), "R10", "write-back endpoint", int'(d_ep), ep);
        end else if (err_at > 0) begin
            chk(dn == 0, "R9", "no write-back after error", dn, 0);
        end else begin
            chk(dn == 0, "R7", "no write-back after overrun", dn, 0);
        end
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(desc_rd_req == 1'b0 && rx_ready == 1'b0, "R1", "request/ready after reset",
            int'({desc_rd_req, rx_ready}), 0);
        chk(mem_we == 1'b0 && desc_wr_en == 1'b0, "R1", "writes after reset",
            int'({mem_we, desc_wr_en}), 0);
        chk(xfer_ok == 1'b0 && xfer_fail == 1'b0, "R1", "status after reset",
            int'({xfer_ok, xfer_fail}), 0);
    endtask

    task automatic t_idle_ignored();
        clear_logs();
        @(posedge clk); #1;
        for (int k = 0; k < 4; k++) begin
            rx_valid = 1'b1; rx_data = 8'(k + 1);
            @(posedge clk); #1;
        end
        rx_valid = 1'b0; rx_eop = 1'b1;
        @(posedge clk); #1;
        rx_eop = 1'b0; rx_err = 1'b1;
        @(posedge clk); #1;
        rx_err = 1'b0;
        @(negedge clk);
        chk(wn == 0 && dn == 0, "R1", "idle strobes cause writes", wn + dn, 0);
        chk(ok_n == 0 && fail_n == 0, "R1", "idle strobes cause status", ok_n + fail_n, 0);
    endtask

    // R6: even packet, CRC stored
    task automatic t_even();      run_pkt(1, 2, 16'h0040, 0, 10, 6, 0, 0, 1'b0); endtask
    // R8: odd packet tail flushed with zero upper byte
    task automatic t_odd();       run_pkt(2, 5, 16'h0100, 0, 10, 5, 0, 1, 1'b0); endtask
    // R7: payload equals allocation, CRC clipped, still successful
    task automatic t_exact_fit(); run_pkt(3, 1, 16'h0200, 0, 3, 8, 0, 0, 1'b0); endtask
    // R7: one payload byte more than the allocation
    task automatic t_overrun();   run_pkt(4, 3, 16'h0200, 0, 3, 9, 0, 0, 1'b0); endtask
    // R5: 32-byte units, allocation filled to its last word
    task automatic t_unit32();    run_pkt(5, 7, 16'h0300, 1, 0, 34, 0, 0, 1'b0); endtask
    // R9: error after an odd number of bytes
    task automatic t_error();     run_pkt(6, 4, 16'h0080, 0, 8, 9, 5, 0, 1'b0); endtask
    // R2: byte already presented while the descriptor fetch is stalled
    task automatic t_fetch_wait(); run_pkt(7, 6, 16'h0020, 1, 1, 12, 0, 3, 1'b1); endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_idle_ignored();
        t_even();
        t_odd();
        t_exact_fit();
        t_overrun();
        t_unit32();
        t_error();
        t_fetch_wait();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule